// File: doc/BRIEF.md
# Flash Query and Identifier Read Formatter

This block produces the read data that a parallel flash bank returns while it is in identifier mode or in common-flash-interface query mode. The bank is made of several identical devices wired side by side. Each may be used narrower than its widest data width. The block takes the byte address of a read and divides it down to a per-device table index. It fetches one per-device response, either a query byte from a table built from parameters or a manufacturer or device identifier. It then formats that response as the devices would drive it and replicates it into every device lane of the bank.

A read may be wider than the bank. In that case several bank-wide responses are fetched at consecutive bank-width addresses and placed side by side, and bytes beyond the requested access size read as zero. The result is registered and appears one cycle after the read strobe. Command sequencing and normal array reads are handled elsewhere. A mode input selects which of the two response paths is used.

Top module: `cfi_query_fmt`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `rd_valid` is 0 and `rd_data` is all zero.
- R2: A read strobed with `rd_en` in one cycle gives its result on `rd_data` with `rd_valid` high after the next rising edge. In a cycle without `rd_en`, `rd_valid` is 0 and `rd_data` keeps its previous value.
- R3: The per-device table index is the byte address shifted right by log2(BANK_W) + log2(MAX_DEV_W) - log2(DEV_W).
- R4: In query mode (`id_mode`=0), an index of 82 (0x52) or more returns zero for that bank-wide part of the result.
- R5: When DEV_W differs from MAX_DEV_W and the configuration is not DEV_W=1 with BANK_W of 4 or less, every query-mode read returns zero.
- R6: For a wide device used in byte mode, the query byte fills every byte of MAX_DEV_W instead of being zero-padded. For a device used at its full width, only the lowest byte carries the query value.
- R7: Byte j of each bank-wide response equals byte (j mod DEV_W) of the per-device response, so every device lane of the bank carries the same value.
- R8: In identifier mode (`id_mode`=1), the low 8 bits of the index select the 16-bit MFR_ID (value 0) or DEV_ID (value 1). Any other value returns zero, and higher index bits are ignored.
- R9: `rd_size` gives the access size as log2 of bytes (0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: 8 bytes), capped at DATA_BYTES. Bank-wide part k of the result comes from address `addr`+k*BANK_W and sits at bytes k*BANK_W upward. Bytes at or above the access size are zero.
- R10: The query table holds ASCII "QRY" (0x51, 0x52, 0x59) at indices 0x10 to 0x12 and log2 of the per-device size at 0x27. Its erase-region descriptor holds BLOCKS-1 at 0x2D (low byte) and 0x2E (high byte), and SECTOR_BYTES/256 at 0x2F (low byte) and 0x30 (high byte).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| id_mode | input | 1 | 1 selects identifier responses, 0 selects query table |
| rd_size | input | SIZE_W | Access size as log2 of bytes |
| addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_BYTES*8 | Registered formatted response |
| rd_valid | output | 1 | High for one cycle when rd_data carries a new result |

## Verification
The bench builds two instances that share the same stimulus. The first is a 2-byte bank of byte-wide-used 16-bit devices, which exercises the byte repetition, the two-chunk wide reads and a shift of 2. The second is a 4-byte bank of 16-bit-used 32-bit devices. That configuration is unsupported for queries, so every query read must be zero, while its identifier path shows 16-bit lane replication with a shift of 3. Random addresses span past the end of the table and random sizes include the capped 8-byte code.

// File: rtl/cfiq_pkg.sv
package cfiq_pkg;

  localparam int unsigned QTAB_LEN = 82;

  function automatic int unsigned lg2(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if ((32'd1 << i) <= v) r = i;
    end
    return r;
  endfunction

  // Per-device query table byte for a given index below QTAB_LEN.
  function automatic logic [7:0] qtab_entry(input logic [6:0] ix,
                                            input int unsigned bank_w,
                                            input int unsigned blocks,
                                            input int unsigned sector_b);
    int unsigned last_blk;
    int unsigned size_lg;
    logic [7:0]  v;
    last_blk = blocks - 1;
    size_lg  = lg2(blocks) + lg2(sector_b);
    case (ix)
      7'h10: v = 8'h51;
      7'h11: v = 8'h52;
      7'h12: v = 8'h59;
      7'h13: v = 8'h01;
      7'h15: v = 8'h31;
      7'h1B: v = 8'h45;
      7'h1C: v = 8'h55;
      7'h1F, 7'h20: v = 8'h07;
      7'h21: v = 8'h0A;
      7'h23, 7'h24, 7'h25: v = 8'h04;
      7'h27: v = size_lg[7:0];
      7'h28: v = 8'h02;
      7'h2A: v = (bank_w == 1) ? 8'h08 : 8'h0B;
      7'h2C: v = 8'h01;
      7'h2D: v = last_blk[7:0];
      7'h2E: v = last_blk[15:8];
      7'h2F: v = sector_b[15:8];
      7'h30: v = sector_b[23:16];
      7'h31: v = 8'h50;
      7'h32: v = 8'h52;
      7'h33: v = 8'h49;
      7'h34: v = 8'h31;
      7'h35: v = 8'h30;
      7'h3F: v = 8'h01;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // Number of result bytes kept for a log2 size code, capped at max_bytes.
  function automatic int unsigned keep_bytes(input int unsigned size_code,
                                             input int unsigned max_bytes);
    int unsigned lim;
    lim = lg2(max_bytes);
    if (size_code > lim) return max_bytes;
    return 32'd1 << size_code;
  endfunction

endpackage

// File: rtl/cfiq_rom.sv
module cfiq_rom
  import cfiq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int BANK_W       = 2,
  parameter int BLOCKS       = 64,
  parameter int SECTOR_BYTES = 32'h20000
) (
  input  logic [ADDR_W-1:0] idx,
  output logic [7:0]        q,
  output logic              oob
);
  localparam logic [ADDR_W-1:0] TAB_END = ADDR_W'(QTAB_LEN);

  always_comb begin
    oob = (idx >= TAB_END);
    q   = oob ? 8'h00 : qtab_entry(idx[6:0], BANK_W, BLOCKS, SECTOR_BYTES);
  end
endmodule

// File: rtl/cfiq_chunk.sv
module cfiq_chunk
  import cfiq_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          BANK_W       = 2,
  parameter int          DEV_W        = 1,
  parameter int          MAX_DEV_W    = 2,
  parameter int          BLOCKS       = 64,
  parameter int          SECTOR_BYTES = 32'h20000,
  parameter logic [15:0] MFR_ID       = 16'h0089,
  parameter logic [15:0] DEV_ID       = 16'h0018
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                id_mode,
  input  logic [ADDR_W-1:0]   addr,
  output logic [BANK_W*8-1:0] chunk
);
  localparam int unsigned SHIFT    = lg2(BANK_W) + lg2(MAX_DEV_W) - lg2(DEV_W);
  localparam bit          NARROWED = (DEV_W != MAX_DEV_W);
  localparam bit          UNSUP    = NARROWED && ((DEV_W != 1) || (BANK_W > 4));
  localparam int          RB       = (MAX_DEV_W > 2) ? MAX_DEV_W : 2;

  logic [ADDR_W-1:0] tab_idx;
  logic [7:0]        q;
  logic              q_oob;
  logic              id_other;
  logic [RB*8-1:0]   dev_resp;

  assign tab_idx = addr >> SHIFT;

  cfiq_rom #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLOCKS(BLOCKS), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_rom (
    .idx(tab_idx), .q(q), .oob(q_oob)
  );

  always_comb begin
    id_other = (tab_idx[7:0] > 8'd1);
    dev_resp = '0;
    if (id_mode) begin
      if (tab_idx[7:0] == 8'd0)      dev_resp[15:0] = MFR_ID;
      else if (tab_idx[7:0] == 8'd1) dev_resp[15:0] = DEV_ID;
    end else if (!q_oob && !UNSUP) begin
      for (int b = 0; b < RB; b++) begin
        if (b == 0 || (NARROWED && b < MAX_DEV_W)) dev_resp[b*8 +: 8] = q;
      end
    end
  end

  // Lane replication: every device lane copies the per-device response.
  for (genvar j = 0; j < BANK_W; j++) begin : g_lane
    assign chunk[j*8 +: 8] = dev_resp[(j % DEV_W)*8 +: 8];
  end

  p_oob_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_mode && q_oob) |-> (chunk == '0));

  p_id_other_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && id_other) |-> (chunk == '0));

  if (UNSUP) begin : g_unsup_chk
    p_unsup_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !id_mode |-> (chunk == '0));
  end
endmodule

// File: rtl/cfi_query_fmt.sv
module cfi_query_fmt
  import cfiq_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_BYTES   = 4,
  parameter int          SIZE_W       = 2,
  parameter int          BANK_W       = 2,
  parameter int          DEV_W        = 1,
  parameter int          MAX_DEV_W    = 2,
  parameter int          BLOCKS       = 64,
  parameter int          SECTOR_BYTES = 32'h20000,
  parameter logic [15:0] MFR_ID       = 16'h0089,
  parameter logic [15:0] DEV_ID       = 16'h0018
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic                    id_mode,
  input  logic [SIZE_W-1:0]       rd_size,
  input  logic [ADDR_W-1:0]       addr,
  output logic [DATA_BYTES*8-1:0] rd_data,
  output logic                    rd_valid
);
  localparam int NCHUNK    = (DATA_BYTES > BANK_W) ? (DATA_BYTES / BANK_W) : 1;
  localparam int WIDE_BITS = NCHUNK * BANK_W * 8;
  localparam int DBITS     = DATA_BYTES * 8;

  logic [WIDE_BITS-1:0] wide;
  logic [DBITS-1:0]     fmt;
  int unsigned          kept;

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    logic [ADDR_W-1:0] chunk_addr;
    assign chunk_addr = addr + ADDR_W'(k * BANK_W);
    cfiq_chunk #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W),
      .BLOCKS(BLOCKS), .SECTOR_BYTES(SECTOR_BYTES), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) u_chunk (
      .clk(clk), .rst_n(rst_n), .id_mode(id_mode), .addr(chunk_addr),
      .chunk(wide[k*BANK_W*8 +: BANK_W*8])
    );
  end

  always_comb begin
    kept = keep_bytes(32'(rd_size), DATA_BYTES);
    for (int b = 0; b < DATA_BYTES; b++) begin
      fmt[b*8 +: 8] = (b < kept) ? wide[b*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= fmt;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  if (DATA_BYTES > 1) begin : g_mask_chk
    p_byte_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_size == '0) |=> (rd_data[DBITS-1:8] == '0));
  end
endmodule

// File: tb/sim_cfi_query_fmt.sv
module sim_cfi_query_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        id_mode = 1'b0;
  logic [1:0]  rd_size = 2'd0;
  logic [15:0] addr = 16'd0;
  logic [31:0] d0, d1;
  logic        v0, v1;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cfi_query_fmt u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .id_mode(id_mode),
    .rd_size(rd_size), .addr(addr), .rd_data(d0), .rd_valid(v0)
  );

  cfi_query_fmt #(
    .BANK_W(4), .DEV_W(2), .MAX_DEV_W(4), .MFR_ID(16'h1234), .DEV_ID(16'hABCD)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .id_mode(id_mode),
    .rd_size(rd_size), .addr(addr), .rd_data(d1), .rd_valid(v1)
  );

  function automatic int lgb(input int v);
    int r = 0;
    while ((1 << (r + 1)) <= v) r++;
    return r;
  endfunction

  function automatic logic [7:0] tbl(input int ix, input int bank, input int blocks, input int sect);
    int n = blocks - 1;
    if (ix == 16) return 8'h51;
    if (ix == 17 || ix == 50) return 8'h52;
    if (ix == 18) return 8'h59;
    if (ix == 19 || ix == 44 || ix == 63) return 8'h01;
    if (ix == 21 || ix == 52) return 8'h31;
    if (ix == 27) return 8'h45;
    if (ix == 28) return 8'h55;
    if (ix == 31 || ix == 32) return 8'h07;
    if (ix == 33) return 8'h0A;
    if (ix >= 35 && ix <= 37) return 8'h04;
    if (ix == 39) return 8'(lgb(blocks) + lgb(sect));
    if (ix == 40) return 8'h02;
    if (ix == 42) return (bank == 1) ? 8'h08 : 8'h0B;
    if (ix == 45) return 8'(n & 255);
    if (ix == 46) return 8'((n >> 8) & 255);
    if (ix == 47) return 8'((sect >> 8) & 255);
    if (ix == 48) return 8'((sect >> 16) & 255);
    if (ix == 49) return 8'h50;
    if (ix == 51) return 8'h49;
    if (ix == 53) return 8'h30;
    return 8'h00;
  endfunction

  function automatic logic [7:0] dev_byte(input bit idm, input int ca, input int lane,
      input int bank, input int dev, input int maxd, input logic [15:0] mfr, input logic [15:0] did);
    int sh = lgb(bank) + lgb(maxd) - lgb(dev);
    int ix = ca >> sh;
    logic [31:0] v;
    if (idm) begin
      v = ((ix & 255) == 0) ? {16'h0, mfr} : ((ix & 255) == 1) ? {16'h0, did} : 32'h0;
      return v[lane*8 +: 8];
    end
    if (dev != maxd && (dev != 1 || bank > 4)) return 8'h00;
    if (ix >= 82) return 8'h00;
    if (lane == 0 || dev != maxd) return tbl(ix, bank, 64, 32'h20000);
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_read(input bit idm, input int a, input int sz,
      input int bank, input int dev, input int maxd, input logic [15:0] mfr, input logic [15:0] did);
    int nb = (sz >= 2) ? 4 : (1 << sz);
    logic [31:0] r = 32'h0;
    for (int p = 0; p < nb; p++) begin
      r[p*8 +: 8] = dev_byte(idm, (a + (p / bank) * bank) & 16'hFFFF, (p % bank) % dev,
                             bank, dev, maxd, mfr, did);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic rd(input bit m, input logic [15:0] a, input logic [1:0] s);
    @(negedge clk);
    rd_en = 1'b1; id_mode = m; addr = a; rd_size = s;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input bit m, input logic [15:0] a, input logic [1:0] s);
    rd(m, a, s);
    chk({req, " u0"}, d0, exp_read(m, a, s, 2, 1, 2, 16'h0089, 16'h0018));
    chk({req, " u1"}, d1, exp_read(m, a, s, 4, 2, 4, 16'h1234, 16'hABCD));
    chk({req, " valid"}, {30'd0, v1, v0}, 32'd3);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    chk("R1 reset data", d0 | d1, 32'h0);
    chk("R1 reset valid", {30'd0, v1, v0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {d0[30:0], v0}, 32'h0);

    // R10 table strings and descriptors (u0 shift is 2)
    rd(1'b0, 16'h0040, 2'd0); chk("R10 Q", d0, 32'h51);
    rd(1'b0, 16'h0048, 2'd0); chk("R10 Y", d0, 32'h59);
    rd(1'b0, 16'h00B4, 2'd0); chk("R10 blocks-1", d0, 32'h3F);
    rd(1'b0, 16'h00B8, 2'd0); chk("R10 blocks-1 high", d0, 32'h00);
    rd(1'b0, 16'h00C0, 2'd0); chk("R10 sector/256 high", d0, 32'h02);
    rd(1'b0, 16'h009C, 2'd0); chk("R10 size log2", d0, 32'h17);
    // R6 / R7 byte repetition and lane copy
    rd(1'b0, 16'h0044, 2'd1); chk("R6 R7 repeat", d0, 32'h5252);
    // R9 wide read from consecutive bank offsets, R5 unsupported in u1
    rd(1'b0, 16'h0046, 2'd2); chk("R9 wide", d0, 32'h59595252);
    chk("R5 unsupported", d1, 32'h0);
    // R4 table end
    rd(1'b0, 16'h00FC, 2'd0); chk("R4 last used", d0, 32'h01);
    rd(1'b0, 16'h0148, 2'd2); chk("R4 past end", d0, 32'h0);
    // R8 identifier mode, R3 shift of 3 in u1
    rd(1'b1, 16'h0000, 2'd2); chk("R8 mfr u0", d0, 32'h89898989);
    chk("R8 R7 mfr u1", d1, 32'h12341234);
    rd(1'b1, 16'h0008, 2'd2); chk("R3 R8 dev u1", d1, 32'hABCDABCD);
    rd(1'b1, 16'h0010, 2'd2); chk("R8 other", d1, 32'h0);
    rd(1'b1, 16'h0800, 2'd1); chk("R8 high bits", d0, 32'h8989);
    // R2 hold when idle
    @(negedge clk);
    chk("R2 hold data", d0, 32'h8989);
    chk("R2 idle valid", {31'd0, v0}, 32'd0);
    // R9 capped size code
    rd(1'b0, 16'h0040, 2'd3); chk("R9 cap", d0, 32'h51515151);

    for (int n = 0; n < 400; n++) begin
      rd_chk("R3 R9 random", 1'($urandom % 2), 16'($urandom % 16'h0200), 2'($urandom % 4));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule